// File: doc/BRIEF.md
# UART Interrupt Enable and Status Controller

This block is the register and interrupt-routing stage of a UART. Software turns interrupt sources on and off through a pair of registers: one sets enable bits and one clears them, so separate handlers can change their own bit without a read-modify-write. The block latches line errors, a transmit-finished event and changes on the clear-to-send input as sticky flags. Only a write of one clears a sticky flag, and reads never change state.

The transmitter, receiver and flow-control logic supply event pulses and status levels. The block turns them into three registered request lines: transmit, receive and status. A redirect control bit moves the transmit and receive requests onto the status line, for systems that have no separate channel for them. The block also holds the bit-rate divisor, with its low and high bytes at separate addresses.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After reset all enable bits, all sticky flags, all three request outputs and the redirect bit are zero. `divisor` equals the parameter DIV_RST.
- R2: A write to address 0 sets each enable bit whose data bit is one. A write to address 1 clears each enable bit whose data bit is one. Zero data bits leave enables unchanged. A read of either address returns the enables. Enable bits: 0 receive, 1 transmit, 2 line error, 3 modem status, 4 transmit finished, 5 receive count.
- R3: Read data is registered and appears one cycle after the read strobe. No read changes any state.
- R4: Line status (address 2) holds sticky error flags: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break. An error pulse sets its flag. The flag stays set until a write to address 2 with a one in that bit.
- R5: Line status bit 4 is the transmit-finished flag. It sets when `tx_empty` rises and clears only when a one is written to it. Bits 5, 6 and 7 read the live `tx_empty`, `thr_empty` and `rx_ready` levels.
- R6: Modem status (address 3) bit 0 is a sticky flag that sets on any change of `cts_in` and clears when a one is written to it. Bit 1 reads `cts_in` live. Bit 2 reads `rx_cnt_hit` live.
- R7: When a hardware set event and a write-one clear hit the same sticky flag in the same cycle, the flag ends set.
- R8: `irq_rx` follows (receive enable AND `rx_ready`) and `irq_tx` follows (transmit enable AND `thr_empty`), each registered with one cycle of delay.
- R9: `irq_stat` is high one cycle after any of these holds: an error flag is set with the line enable on; the CTS flag is set with the modem enable on; the transmit-finished flag is set with its enable on; `rx_cnt_hit` is high with the receive-count enable on. It drops one cycle after all of them stop holding.
- R10: When control bit 0 (address 4) is one, `irq_rx` and `irq_tx` stay low and their requests are ORed into `irq_stat`.
- R11: Address 5 holds the low byte and address 6 the high byte of `divisor`. Each byte can be written and read back on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_ready | input | 1 | Receive data available (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| tx_empty | input | 1 | Transmitter fully idle (level) |
| err_pulse | input | 4 | Error events: overrun, parity, framing, break |
| cts_in | input | 1 | Clear-to-send input level |
| rx_cnt_hit | input | 1 | Receive FIFO count at watermark (level) |
| divisor | output | 2*DATA_W | Bit-rate divisor |
| irq_tx | output | 1 | Transmit request |
| irq_rx | output | 1 | Receive request |
| irq_stat | output | 1 | Status request |

## Verification
The bench builds the block with its defaults: an 8-bit data bus and a divisor reset value of one. With these values every line status flag, each enable bit and both divisor bytes fit in single register reads, so each field position in the requirements can be checked directly. The bench also lines up a clear write and an error pulse in one cycle to reach the set-wins case. It toggles the redirect bit while requests are active.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int NUM_ERR = 4;
  localparam int ENA_W   = 6;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_TFIN  = 4;
  localparam int EN_RXCNT = 5;

  localparam int LS_TFIN  = NUM_ERR;
  localparam int LS_TEMT  = NUM_ERR + 1;
  localparam int LS_THRE  = NUM_ERR + 2;
  localparam int LS_RDY   = NUM_ERR + 3;
  localparam int LS_W     = NUM_ERR + 4;
  localparam int LS_STK_W = NUM_ERR + 1;

  localparam logic [2:0] A_ENA_SET = 3'd0;
  localparam logic [2:0] A_ENA_CLR = 3'd1;
  localparam logic [2:0] A_LSTAT   = 3'd2;
  localparam logic [2:0] A_MSTAT   = 3'd3;
  localparam logic [2:0] A_CTRL    = 3'd4;
  localparam logic [2:0] A_DIV_LO  = 3'd5;
  localparam logic [2:0] A_DIV_HI  = 3'd6;
endpackage

// File: rtl/uart_evt_enables.sv
module uart_evt_enables #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] mask,
  output logic [W-1:0] ena_q
);
  logic [W-1:0] set_m, clr_m;
  assign set_m = set_we ? mask : '0;
  assign clr_m = clr_we ? mask : '0;

  always_ff @(posedge clk) begin
    if (rst) ena_q <= '0;
    else     ena_q <= (ena_q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/uart_evt_sticky.sv
module uart_evt_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_i;
    assign clr_i = clr_we & clr_mask[i];
    always_ff @(posedge clk) begin
      if (rst)            q[i] <= 1'b0;
      else if (hw_set[i]) q[i] <= 1'b1;   // new event beats a clear
      else if (clr_i)     q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_evt_route.sv
module uart_evt_route
  import uart_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ENA_W-1:0] ena,
  input  logic             redirect,
  input  logic             rx_ready,
  input  logic             thr_empty,
  input  logic             err_any,
  input  logic             cts_chg,
  input  logic             tfin,
  input  logic             rx_cnt,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_stat
);
  logic rx_req, tx_req, st_req;
  assign rx_req = ena[EN_RX] & rx_ready;
  assign tx_req = ena[EN_TX] & thr_empty;
  assign st_req = (ena[EN_LINE]  & err_any)
                | (ena[EN_MODEM] & cts_chg)
                | (ena[EN_TFIN]  & tfin)
                | (ena[EN_RXCNT] & rx_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx   <= 1'b0;
      irq_rx   <= 1'b0;
      irq_stat <= 1'b0;
    end else begin
      irq_tx   <= tx_req & ~redirect;
      irq_rx   <= rx_req & ~redirect;
      irq_stat <= st_req | (redirect & (rx_req | tx_req));
    end
  end
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_RST = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [2:0]            bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  rx_ready,
  input  logic                  thr_empty,
  input  logic                  tx_empty,
  input  logic [NUM_ERR-1:0]    err_pulse,
  input  logic                  cts_in,
  input  logic                  rx_cnt_hit,
  output logic [2*DATA_W-1:0]   divisor,
  output logic                  irq_tx,
  output logic                  irq_rx,
  output logic                  irq_stat
);
  localparam int DIV_W = 2 * DATA_W;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

  logic we_set, we_clr, we_ls, we_ms, we_ctrl, we_dlo, we_dhi;
  assign we_set  = bus_wr && (bus_addr == A_ENA_SET);
  assign we_clr  = bus_wr && (bus_addr == A_ENA_CLR);
  assign we_ls   = bus_wr && (bus_addr == A_LSTAT);
  assign we_ms   = bus_wr && (bus_addr == A_MSTAT);
  assign we_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign we_dlo  = bus_wr && (bus_addr == A_DIV_LO);
  assign we_dhi  = bus_wr && (bus_addr == A_DIV_HI);

  // enables
  logic [ENA_W-1:0] ena_q;
  uart_evt_enables #(.W(ENA_W)) u_ena (
    .clk(clk), .rst(rst), .set_we(we_set), .clr_we(we_clr),
    .mask(bus_wdata[ENA_W-1:0]), .ena_q(ena_q)
  );

  // edge detect for transmitter-empty and clear-to-send
  logic temt_prev, cts_prev;
  always_ff @(posedge clk) begin
    temt_prev <= tx_empty;
    cts_prev  <= cts_in;
  end

  // line-status sticky flags: errors plus transmit finished
  logic [LS_STK_W-1:0] ls_set, ls_q;
  assign ls_set = {tx_empty & ~temt_prev, err_pulse};
  uart_evt_sticky #(.W(LS_STK_W)) u_line (
    .clk(clk), .rst(rst), .hw_set(ls_set), .clr_we(we_ls),
    .clr_mask(bus_wdata[LS_STK_W-1:0]), .q(ls_q)
  );

  // modem-status sticky flag
  logic [0:0] ms_set, ms_q;
  assign ms_set = cts_in ^ cts_prev;
  uart_evt_sticky #(.W(1)) u_modem (
    .clk(clk), .rst(rst), .hw_set(ms_set), .clr_we(we_ms),
    .clr_mask(bus_wdata[0:0]), .q(ms_q)
  );

  // control and divisor
  logic redir_q;
  logic [DATA_W-1:0] div_lo, div_hi;
  always_ff @(posedge clk) begin
    if (rst) begin
      redir_q <= 1'b0;
      div_lo  <= DIV_INIT[DATA_W-1:0];
      div_hi  <= DIV_INIT[DIV_W-1:DATA_W];
    end else begin
      if (we_ctrl) redir_q <= bus_wdata[0];
      if (we_dlo)  div_lo  <= bus_wdata;
      if (we_dhi)  div_hi  <= bus_wdata;
    end
  end
  assign divisor = {div_hi, div_lo};

  // read path
  logic [DATA_W-1:0] ls_view, ms_view, rd_mux;
  always_comb begin
    ls_view = '0;
    ls_view[LS_STK_W-1:0] = ls_q;
    ls_view[LS_TEMT] = tx_empty;
    ls_view[LS_THRE] = thr_empty;
    ls_view[LS_RDY]  = rx_ready;
    ms_view = '0;
    ms_view[0] = ms_q[0];
    ms_view[1] = cts_in;
    ms_view[2] = rx_cnt_hit;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_ENA_SET, A_ENA_CLR: rd_mux[ENA_W-1:0] = ena_q;
      A_LSTAT:  rd_mux = ls_view;
      A_MSTAT:  rd_mux = ms_view;
      A_CTRL:   rd_mux[0] = redir_q;
      A_DIV_LO: rd_mux = div_lo;
      A_DIV_HI: rd_mux = div_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // request routing
  uart_evt_route u_route (
    .clk(clk), .rst(rst), .ena(ena_q), .redirect(redir_q),
    .rx_ready(rx_ready), .thr_empty(thr_empty),
    .err_any(|ls_q[NUM_ERR-1:0]), .cts_chg(ms_q[0]),
    .tfin(ls_q[LS_TFIN]), .rx_cnt(rx_cnt_hit),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_stat(irq_stat)
  );
endmodule

// File: rtl/uart_evt_ctrl_chk.sv
module uart_evt_ctrl_chk
  import uart_evt_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic [2:0]          bus_addr,
  input logic [ENA_W-1:0]    ena_q,
  input logic [LS_STK_W-1:0] ls_q,
  input logic                redir_q,
  input logic                rx_ready,
  input logic                irq_tx,
  input logic                irq_rx,
  input logic                irq_stat
);
  // R1: request lines are low in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_tx && !irq_rx && !irq_stat));

  // R2: an enable bit only rises after a write to the set address
  assert_ena_rise_needs_set_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr && bus_addr == A_ENA_SET) |-> ((ena_q & ~$past(ena_q)) == '0));

  // R4: error flags never fall without a bus write
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> ((~ls_q[NUM_ERR-1:0] & $past(ls_q[NUM_ERR-1:0])) == '0));

  // R8: enabled receive level raises the receive line next cycle
  assert_rx_follow_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ena_q[EN_RX] && rx_ready && !redir_q) |-> irq_rx);

  // R10: redirect keeps the dedicated lines low
  assert_redirect_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(redir_q) |-> (!irq_rx && !irq_tx));
endmodule

bind uart_evt_ctrl uart_evt_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ena_q(ena_q), .ls_q(ls_q), .redir_q(redir_q), .rx_ready(rx_ready),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_stat(irq_stat)
);

// File: tb/uart_evt_ctrl_tb.sv
module uart_evt_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_ready = 0, thr_empty = 0, tx_empty = 0, cts_in = 0, rx_cnt_hit = 0;
  logic [3:0] err_pulse = '0;
  logic [15:0] divisor;
  logic       irq_tx, irq_rx, irq_stat;

  int checks = 0;
  int fails  = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  uart_evt_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
    .thr_empty(thr_empty), .tx_empty(tx_empty), .err_pulse(err_pulse),
    .cts_in(cts_in), .rx_cnt_hit(rx_cnt_hit), .divisor(divisor),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_stat(irq_stat)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!irq_tx && !irq_rx && !irq_stat, "R1 irqs", {irq_tx, irq_rx, irq_stat}, 0);
    chk(divisor == 16'd1, "R1 divisor", divisor, 1);
    rd(3'd0, d); chk(d == 0, "R1 enables", d, 0);
    rd(3'd2, d); chk(d == 0, "R1 line status", d, 0);
    rd(3'd4, d); chk(d == 0, "R1 redirect", d, 0);
  endtask

  task automatic t_enables;
    wr(3'd0, 8'h05); rd(3'd0, d); chk(d == 8'h05, "R2 set", d, 8'h05);
    wr(3'd0, 8'h02); rd(3'd0, d); chk(d == 8'h07, "R2 set zeros no effect", d, 8'h07);
    wr(3'd1, 8'h04); rd(3'd1, d); chk(d == 8'h03, "R2 clear via clr addr", d, 8'h03);
    wr(3'd1, 8'h00); rd(3'd0, d); chk(d == 8'h03, "R2 clear zeros no effect", d, 8'h03);
    wr(3'd1, 8'h3F);
  endtask

  task automatic t_rxtx;
    wr(3'd0, 8'h03);
    @(negedge clk); rx_ready = 1; thr_empty = 1;
    @(negedge clk);
    chk(irq_rx == 1, "R8 rx request", irq_rx, 1);
    chk(irq_tx == 1, "R8 tx request", irq_tx, 1);
    wr(3'd1, 8'h01); @(negedge clk);
    chk(irq_rx == 0 && irq_tx == 1, "R8 rx disabled", {irq_rx, irq_tx}, 1);
    rx_ready = 0; thr_empty = 0; wr(3'd1, 8'h3F); cyc(1);
  endtask

  task automatic t_errors;
    wr(3'd0, 8'h04);
    @(negedge clk); err_pulse = 4'b0010;
    @(negedge clk); err_pulse = 0;
    @(negedge clk);
    chk(irq_stat == 1, "R9 line error request", irq_stat, 1);
    rd(3'd2, d); chk(d == 8'h02, "R4 parity flag", d, 8'h02);
    rd(3'd2, d); chk(d == 8'h02, "R3 read does not clear", d, 8'h02);
    wr(3'd2, 8'h01); rd(3'd2, d); chk(d == 8'h02, "R4 clear other bit", d, 8'h02);
    wr(3'd2, 8'h02); rd(3'd2, d); chk(d == 8'h00, "R4 clear parity", d, 0);
    chk(irq_stat == 0, "R9 request dropped", irq_stat, 0);
    wr(3'd1, 8'h3F);
  endtask

  task automatic t_setwins;
    @(negedge clk); err_pulse = 4'b0001;
    @(negedge clk); err_pulse = 0;
    @(negedge clk); bus_wr = 1; bus_addr = 3'd2; bus_wdata = 8'h01; err_pulse = 4'b0001;
    @(negedge clk); bus_wr = 0; err_pulse = 0;
    rd(3'd2, d); chk(d == 8'h01, "R7 set wins over clear", d, 8'h01);
    wr(3'd2, 8'h01); rd(3'd2, d); chk(d == 8'h00, "R7 later clear", d, 0);
  endtask

  task automatic t_tfin;
    @(negedge clk); tx_empty = 1;
    rd(3'd2, d); chk(d == 8'h30, "R5 finished flag and live level", d, 8'h30);
    wr(3'd0, 8'h10); @(negedge clk);
    chk(irq_stat == 1, "R9 finished request", irq_stat, 1);
    wr(3'd2, 8'h10); rd(3'd2, d); chk(d == 8'h20, "R5 cleared, no new rise", d, 8'h20);
    tx_empty = 0; wr(3'd1, 8'h3F); cyc(1);
  endtask

  task automatic t_cts;
    @(negedge clk); cts_in = 1;
    @(negedge clk);
    rd(3'd3, d); chk(d == 8'h03, "R6 change flag and live cts", d, 8'h03);
    wr(3'd0, 8'h08); @(negedge clk);
    chk(irq_stat == 1, "R9 modem request", irq_stat, 1);
    wr(3'd3, 8'h01); rd(3'd3, d); chk(d == 8'h02, "R6 cleared", d, 8'h02);
    @(negedge clk); cts_in = 0;
    @(negedge clk); rd(3'd3, d); chk(d == 8'h01, "R6 falling change", d, 8'h01);
    wr(3'd3, 8'h01); wr(3'd1, 8'h3F);
  endtask

  task automatic t_rxcnt;
    wr(3'd0, 8'h20);
    @(negedge clk); rx_cnt_hit = 1;
    @(negedge clk); chk(irq_stat == 1, "R9 count request", irq_stat, 1);
    rd(3'd3, d); chk(d == 8'h04, "R6 live count bit", d, 8'h04);
    rx_cnt_hit = 0;
    @(negedge clk); chk(irq_stat == 0, "R9 count drop", irq_stat, 0);
    wr(3'd1, 8'h3F);
  endtask

  task automatic t_redirect;
    wr(3'd4, 8'h01); wr(3'd0, 8'h03);
    @(negedge clk); rx_ready = 1;
    @(negedge clk);
    chk(irq_rx == 0 && irq_stat == 1, "R10 rx to status", {irq_rx, irq_stat}, 1);
    thr_empty = 1; rx_ready = 0;
    @(negedge clk);
    chk(irq_tx == 0 && irq_stat == 1, "R10 tx to status", {irq_tx, irq_stat}, 1);
    wr(3'd4, 8'h00); @(negedge clk);
    chk(irq_tx == 1 && irq_stat == 0, "R10 redirect off", {irq_tx, irq_stat}, 2);
    thr_empty = 0; wr(3'd1, 8'h3F);
  endtask

  task automatic t_divisor;
    wr(3'd5, 8'h34); chk(divisor == 16'h0034, "R11 low byte", divisor, 16'h0034);
    wr(3'd6, 8'h12); chk(divisor == 16'h1234, "R11 high byte", divisor, 16'h1234);
    rd(3'd5, d); chk(d == 8'h34, "R11 read low", d, 8'h34);
    rd(3'd6, d); chk(d == 8'h12, "R11 read high", d, 8'h12);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_enables;
    t_rxtx;
    t_errors;
    t_setwins;
    t_tfin;
    t_cts;
    t_rxcnt;
    t_redirect;
    t_divisor;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule